// File: doc/BRIEF.md
# Iterative Multi-Mode Integer Multiplier

This block is a multiply execution unit for a processor datapath. A start strobe captures two 64-bit operand buses, a two-bit product type and a two-bit operand width. The unit then forms the product over several clock cycles by accumulating shifted partial products one digit of the second operand at a time. When the result is ready it raises a one-cycle completion pulse. The result stays on the product bus until the next completion.

Operands of 16 or 32 bits can yield a truncated product of the operand width. They can also yield a full double-width product, treating the operands as unsigned by unsigned, signed by signed, or signed first by unsigned second. A third width gives an unsigned 64 by 64 product of 128 bits. Signed operands are sign-extended to the result width before accumulation, so every result is exact in two's complement. The number of cycles scales with the result width, so narrow products finish sooner than wide ones.

Top module: `mxu_multiplier`

## Requirements
- R1: With width code 0 or 1 and mode 0, the product is the low 16 (width 0) or 32 (width 1) bits of the unsigned product of the operands, and every higher product bit is 0.
- R2: With width code 0 or 1 and mode 1, the product is the full 32-bit (width 0) or 64-bit (width 1) unsigned product, and bits above it are 0.
- R3: With width code 0 or 1 and mode 2, both operands are signed and the product is the full 32-bit or 64-bit two's-complement product, and bits above it are 0.
- R4: With width code 0 or 1 and mode 3, operand A is signed and operand B is unsigned, and the product is the full 32-bit or 64-bit two's-complement product, and bits above it are 0.
- R5: With width code 2 or 3, the product is the full 128-bit unsigned product of the two 64-bit operands, whatever the mode.
- R6: Operand bits above bit 15 (width 0) or bit 31 (width 1) have no effect on the product.
- R7: done is high for exactly one cycle, RB/4+1 rising edges after the edge that samples start, where RB is the result width in bits (16, 32, 64 or 128).
- R8: busy is high from the edge that samples start until the edge that raises done. A start while busy is high is ignored, and the running operation completes with its own operands.
- R9: The product bus changes only on the edge that raises done, and holds its value otherwise.
- R10: After reset, done and busy are 0 and the product bus is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply when idle |
| mode | input | 2 | Product type: 0 truncated, 1 unsigned, 2 signed×signed, 3 signed×unsigned |
| width | input | 2 | Operand width: 0 = 16-bit, 1 = 32-bit, 2 or 3 = 64-bit unsigned |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 128 | Result, zero above the result width |

## Verification
A wrong sign-extension or width mask shows up at the product bus on the completion pulse. It appears as wrong high bits, most clearly with operands at the most negative value or all ones. A miscounted digit counter moves the completion pulse off its expected edge and usually corrupts the product as well. Both are caught in the cycle that done rises. A start that leaks into a busy unit reloads the operands, and the product then matches the intruding operands instead of the original ones.

// File: rtl/mxu_pkg.sv
package mxu_pkg;

  localparam int OPD_W  = 64;
  localparam int PROD_W = 128;
  localparam int CNT_W  = 8;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mulCtrlT;

  // Result width in bits for a given product type and operand width.
  function automatic logic [CNT_W-1:0] resultBits(input logic [1:0] m, input logic [1:0] w);
    logic [CNT_W-1:0] r;
    if (w[1])          r = 8'd128;
    else if (w == 2'd0) r = (m == 2'd0) ? 8'd16 : 8'd32;
    else                r = (m == 2'd0) ? 8'd32 : 8'd64;
    return r;
  endfunction

endpackage

// File: rtl/mxu_ctrl.sv
module mxu_ctrl
  import mxu_pkg::*;
#(
  parameter int DIG_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic [1:0] width,
  output mulCtrlT    ctl,
  output logic       busy
);

  localparam int SHIFT = $clog2(DIG_W);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} stateT;

  stateT            stateR;
  logic [CNT_W-1:0] cntR;
  logic [CNT_W-1:0] digits;

  assign digits = resultBits(mode, width) >> SHIFT;

  always_comb begin
    ctl        = '0;
    ctl.load   = (stateR == ST_IDLE) && start;
    ctl.step   = (stateR == ST_RUN);
    ctl.finish = (stateR == ST_FIN);
  end

  assign busy = (stateR != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      cntR   <= '0;
    end else begin
      case (stateR)
        ST_IDLE: if (start) begin
          stateR <= ST_RUN;
          cntR   <= digits - 1'b1;
        end
        ST_RUN: begin
          if (cntR == '0) stateR <= ST_FIN;
          else            cntR   <= cntR - 1'b1;
        end
        default: stateR <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.step, ctl.finish})); // R8
  AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == ST_RUN && cntR != '0) |=> (stateR == ST_RUN)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stateR != ST_FIN) |=> busy); // R8

endmodule

// File: rtl/mxu_datapath.sv
module mxu_datapath
  import mxu_pkg::*;
#(
  parameter int DIG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulCtrlT           ctl,
  input  logic [1:0]        mode,
  input  logic [1:0]        width,
  input  logic [OPD_W-1:0]  opA,
  input  logic [OPD_W-1:0]  opB,
  output logic              done,
  output logic [PROD_W-1:0] product
);

  logic [PROD_W-1:0] accR, mcandR, multR, productR;
  logic [CNT_W-1:0]  resBitsR;
  logic              doneR;
  logic [PROD_W-1:0] extA, extB, digitSum;
  logic              aSigned, bSigned;
  logic [PROD_W-1:0] ppTerm [DIG_W];

  function automatic logic [PROD_W-1:0] extendOp(input logic [OPD_W-1:0] v,
                                                 input logic [1:0] w, input logic sgn);
    logic [PROD_W-1:0] r;
    if (w == 2'd0)      r = {{(PROD_W-16){sgn & v[15]}}, v[15:0]};
    else if (w == 2'd1) r = {{(PROD_W-32){sgn & v[31]}}, v[31:0]};
    else                r = {{(PROD_W-OPD_W){1'b0}}, v};
    return r;
  endfunction

  function automatic logic [PROD_W-1:0] maskFor(input logic [CNT_W-1:0] bits);
    logic [PROD_W-1:0] r;
    if (bits == 8'd128) r = '1;
    else                r = (128'd1 << bits) - 128'd1;
    return r;
  endfunction

  assign aSigned = !width[1] && mode[1];
  assign bSigned = !width[1] && (mode == 2'd2);
  assign extA    = extendOp(opA, width, aSigned);
  assign extB    = extendOp(opB, width, bSigned);

  for (genvar g = 0; g < DIG_W; g++) begin : gPartial
    assign ppTerm[g] = multR[g] ? (mcandR << g) : '0;
  end

  always_comb begin
    digitSum = '0;
    for (int i = 0; i < DIG_W; i++) digitSum = digitSum + ppTerm[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR     <= '0;
      mcandR   <= '0;
      multR    <= '0;
      resBitsR <= '0;
      productR <= '0;
      doneR    <= 1'b0;
    end else begin
      doneR <= ctl.finish;
      if (ctl.load) begin
        accR     <= '0;
        mcandR   <= extA;
        multR    <= extB;
        resBitsR <= resultBits(mode, width);
      end else if (ctl.step) begin
        accR   <= accR + digitSum;
        mcandR <= mcandR << DIG_W;
        multR  <= multR >> DIG_W;
      end
      if (ctl.finish) productR <= accR & maskFor(resBitsR);
    end
  end

  assign done    = doneR;
  assign product = productR;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR); // R7
  AST_DONE_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> $past(ctl.finish)); // R7
  AST_TRUNC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (doneR && resBitsR == 8'd16) |-> (productR[PROD_W-1:16] == '0)); // R1
  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !doneR |-> $stable(productR)); // R9

endmodule

// File: rtl/mxu_multiplier.sv
module mxu_multiplier
  import mxu_pkg::*;
#(
  parameter int DIG_W = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [1:0]    width,
  input  logic [63:0]   opA,
  input  logic [63:0]   opB,
  output logic          busy,
  output logic          done,
  output logic [127:0]  product
);

  mulCtrlT ctl;

  mxu_ctrl #(.DIG_W(DIG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .width(width),
    .ctl(ctl), .busy(busy)
  );

  mxu_datapath #(.DIG_W(DIG_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mode(mode), .width(width),
    .opA(opA), .opB(opB), .done(done), .product(product)
  );

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

endmodule

// File: tb/sim_mxu_multiplier.sv
`timescale 1ns/1ps
module sim_mxu_multiplier;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = '0;
  logic [1:0]   width = '0;
  logic [63:0]  opA = '0;
  logic [63:0]  opB = '0;
  logic         busy, done;
  logic [127:0] product;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  mxu_multiplier u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .width(width),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .product(product)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  function automatic int resBits(input logic [1:0] m, input logic [1:0] w);
    if (w[1]) return 128;
    if (w == 2'd0) return (m == 2'd0) ? 16 : 32;
    return (m == 2'd0) ? 32 : 64;
  endfunction

  function automatic logic [127:0] refProduct(input logic [1:0] m, input logic [1:0] w,
                                              input logic [63:0] a, input logic [63:0] b);
    logic [127:0] ea, eb, p, msk;
    int rb;
    logic sa, sb;
    sa = !w[1] && m[1];
    sb = !w[1] && (m == 2'd2);
    if (w == 2'd0) begin
      ea = sa ? 128'($signed(a[15:0])) : 128'(a[15:0]);
      eb = sb ? 128'($signed(b[15:0])) : 128'(b[15:0]);
    end else if (w == 2'd1) begin
      ea = sa ? 128'($signed(a[31:0])) : 128'(a[31:0]);
      eb = sb ? 128'($signed(b[31:0])) : 128'(b[31:0]);
    end else begin
      ea = 128'(a); eb = 128'(b);
    end
    p  = ea * eb;
    rb = resBits(m, w);
    msk = (rb == 128) ? '1 : ((128'd1 << rb) - 128'd1);
    return p & msk;
  endfunction

  function automatic string reqOf(input logic [1:0] m, input logic [1:0] w);
    if (w[1]) return "R5";
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One multiply; optionally fire an intruding start while busy (R8).
  task automatic runOp(input logic [1:0] m, input logic [1:0] w,
                       input logic [63:0] a, input logic [63:0] b,
                       input bit intrude, input string tag);
    int k;
    logic [127:0] exp, held;
    exp = refProduct(m, w, a, b);
    @(negedge clk);
    mode = m; width = w; opA = a; opB = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    check(busy == 1'b1, "R8", 128'(busy), 128'd1);
    while (k < 200) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (done) break;
      if (intrude && k == 2) begin
        opA = ~a; opB = b ^ 64'h5A5A; mode = ~m; width = w ^ 2'd1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(k == resBits(m, w)/4 + 1, "R7", 128'(k), 128'(resBits(m, w)/4 + 1));
    check(product == exp, (tag != "") ? tag : reqOf(m, w), product, exp);
    check(busy == 1'b0, "R8", 128'(busy), 128'd0);
    held = product;
    opA = ~opA; opB = opB + 64'd3;
    @(posedge clk); @(negedge clk);
    check(done == 1'b0, "R7", 128'(done), 128'd0);
    check(product == held, "R9", product, held);
  endtask

  function automatic logic [63:0] pickOp(input logic [1:0] w);
    logic [63:0] r;
    int sel;
    sel = $urandom_range(0, 7);
    r = {$urandom, $urandom};
    case (sel)
      0: r = (w[1]) ? 64'd0 : (r & ~((w == 2'd0) ? 64'hFFFF : 64'hFFFF_FFFF));
      1: r = (w[1]) ? '1 : (r | ((w == 2'd0) ? 64'hFFFF : 64'hFFFF_FFFF));
      2: r = (w == 2'd0) ? {r[63:16], 16'h8000} :
             (w == 2'd1) ? {r[31:0], 32'h8000_0000} : 64'h8000_0000_0000_0000;
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd7331);
    #20;
    @(negedge clk);
    check(done == 1'b0, "R10", 128'(done), 128'd0);
    check(busy == 1'b0, "R10", 128'(busy), 128'd0);
    check(product == '0, "R10", product, '0);
    rstN = 1'b1;

    // Directed corners
    runOp(2'd0, 2'd0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF, 0, "R1");
    runOp(2'd1, 2'd0, 64'hFFFF, 64'hFFFF, 0, "R2");
    runOp(2'd2, 2'd0, 64'h8000, 64'h8000, 0, "R3");
    runOp(2'd2, 2'd0, 64'hFFFF, 64'h0001, 0, "R3");
    runOp(2'd3, 2'd0, 64'hFFFF, 64'hFFFF, 0, "R4");
    runOp(2'd2, 2'd1, 64'h8000_0000, 64'hFFFF_FFFF, 0, "R3");
    runOp(2'd3, 2'd1, 64'h8000_0000, 64'hFFFF_FFFF, 0, "R4");
    runOp(2'd0, 2'd1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, "R1");
    runOp(2'd2, 2'd2, '1, '1, 0, "R5");
    runOp(2'd0, 2'd3, 64'h8000_0000_0000_0000, 64'h2, 0, "R5");
    // Garbage above the operand width must not matter
    runOp(2'd2, 2'd0, 64'hDEAD_BEEF_1234_8001, 64'hCAFE_F00D_0000_7FFF, 0, "R6");
    runOp(2'd1, 2'd1, 64'hFFFF_FFFF_0000_0003, 64'h1234_5678_0000_0005, 0, "R6");
    // Start while busy must be ignored
    runOp(2'd2, 2'd1, 64'h1234_5678, 64'h8765_4321, 1, "R8");
    runOp(2'd0, 2'd2, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1, "R8");

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m, w;
      m = 2'($urandom_range(0, 3));
      w = 2'($urandom_range(0, 3));
      runOp(m, w, pickOp(w), pickOp(w), (i % 17) == 0, "");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule